// File: doc/BRIEF.md
# Dither Correlation Coefficient Estimator

This block works out two correction coefficients per pipeline stage: a linear gain term and a cubic term. The block drives three pseudo-random ±1 sequences, and the stage under calibration injects them as dither. The block then takes back a residual sample for each dither step, which is the corrected code with the stage decision removed. Multiplying the residual by the first sequence separates the part of the error that depends on gain. Multiplying it by the product of all three sequences separates the cubic part. Everything else in the residual averages towards zero.

Each product is summed over a window of 2^k accepted samples, and the sum is scaled down to a window average. At the end of every window both coefficients of the active stage move by that average, shifted right by a per-term step exponent (a least-mean-square step). A stage is retired once two windows in a row show both averages below a threshold. Stages are visited from the highest index down to index 0, and the block stops after stage 0 with a finished flag. The coefficients live in registers that keep their values between runs, so each calibration run starts from the previous result.

Top module: `pn_lms_estimator`

## Requirements
- R1: Reset behaviour (synchronous, active high). Every gain and cubic coefficient returns to its initial parameter value, all per-stage done bits and the finished flag go to 0, and the active stage index goes to NUM_STAGES-1.
- R2: Dither bits. `pn_bits[0]` is the first sequence, and bits 1 and 2 are the other two. A bit value of 1 stands for +1 and 0 stands for −1. Each bit changes only on the clock edge that accepts a `sample_valid` sample. The three bits are never all stuck, and every one of the 8 combinations occurs.
- R3: The gain correlation adds the residual to its window sum when `pn_bits[0]`=1, and subtracts it when `pn_bits[0]`=0.
- R4: The cubic correlation uses the product of the three signs. The product is +1 exactly when the XOR of the three bits is 1. The residual is added when the product is +1 and subtracted otherwise.
- R5: A window holds 2^L accepted samples, where L is the latched window exponent (values above MAX_LOG2N are clamped). The window average is the window sum arithmetically shifted right by L, rounding towards minus infinity.
- R6: One clock after the window's last sample is accepted, the active stage's gain coefficient grows by (gain average >>> gain step exponent) and its cubic coefficient grows by (cubic average >>> cubic step exponent). Both shifts are arithmetic. The coefficients of the other stages do not change.
- R7: A window is quiet when the magnitudes of both averages are strictly below `quiet_thr`. The second quiet window in a row sets the active stage's done bit, moves the active index down by one and starts an empty window. A window that is not quiet clears the run of quiet windows.
- R8: `start` latches the configuration, sets the active index to NUM_STAGES-1, clears the done bits and the finished flag, and keeps the coefficients. Retiring stage 0 raises `all_done` and stops calibration.
- R9: Samples that arrive while no calibration is running change neither the coefficients nor the flags.
- R10: Changes to the window exponent, step exponents or threshold after `start` have no effect until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and begin a calibration run |
| win_log2 | input | LOGN_W | Window length exponent L (window holds 2^L samples) |
| mu_g_shift | input | SH_W | Right-shift step exponent for the gain update |
| mu_a_shift | input | SH_W | Right-shift step exponent for the cubic update |
| quiet_thr | input | RES_W | Magnitude bound for a quiet window (unsigned) |
| sample_valid | input | 1 | Residual sample present this cycle |
| residual | input | RES_W | Signed residual for the current dither bits |
| pn_bits | output | 3 | Current dither sequence bits (1 = +1) |
| active_stage | output | STG_W | Index of the stage under calibration |
| gain_coef | output | NUM_STAGES*COEF_W | Signed gain coefficients, stage s at bits [s*COEF_W +: COEF_W] |
| cubic_coef | output | NUM_STAGES*COEF_W | Signed cubic coefficients, same packing |
| stage_done | output | NUM_STAGES | Per-stage retired flags |
| all_done | output | 1 | Calibration run finished |

## Verification
The checks inside the design take two things for granted about the inputs. The residual fits in RES_W signed bits, which is what bounds every window average to ±2^(RES_W-1). And `start` never lands in the same cycle as a window-end update. The bench keeps to both. It forms each residual as the bench's own coefficient error times the dither signs, plus a ±1 term that is uncorrelated with either product, with targets chosen so the magnitude stays far inside 12 bits. It also raises `sample_valid` only on alternate cycles and pulses `start` only between runs. With valid on alternate cycles, no sample ever meets a window-end cycle or a stage switch.

// File: rtl/pn_lms_pkg.sv
package pn_lms_pkg;

  localparam int PN_W = 16;

  typedef enum logic [0:0] {
    CAL_IDLE = 1'b0,
    CAL_RUN  = 1'b1
  } cal_state_e;

  // feedback masks; bit 15 is always tapped so the shift map is invertible
  function automatic logic [PN_W-1:0] pn_taps(input int k);
    case (k)
      0:       return 16'hB400;
      1:       return 16'hD008;
      default: return 16'hCA00;
    endcase
  endfunction

  function automatic logic [PN_W-1:0] pn_seed(input int k);
    case (k)
      0:       return 16'h1D2B;
      1:       return 16'hA5F0;
      default: return 16'h0C37;
    endcase
  endfunction

  // product of three signs (1 = +1) is +1 when an odd number of bits are set
  function automatic logic cubic_pos(input logic [2:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic bit_o
);

  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = ^(state_q & TAPS);
  assign bit_o = state_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (adv) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end

  // R2: the sequence only steps on an accepted sample
  assert_pn_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(bit_o));

  // R2: the register never falls into the all-zero lock-up state
  assert_pn_live_R2: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/pn_correlator.sv
module pn_correlator #(
  parameter int RES_W = 14,
  parameter int ACC_W = 27
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    acc_en,
  input  logic                    last,
  input  logic                    sgn_pos,
  input  logic signed [RES_W-1:0] residual,
  output logic signed [ACC_W-1:0] sum_o
);

  logic signed [ACC_W-1:0] res_ext;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sum_q;

  assign res_ext = {{(ACC_W-RES_W){residual[RES_W-1]}}, residual};
  assign term    = sgn_pos ? res_ext : -res_ext;
  assign sum_o   = sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sum_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (acc_en) begin
      if (last) begin
        acc_q <= '0;
        sum_q <= acc_q + term;
      end else begin
        acc_q <= acc_q + term;
      end
    end
  end

  // R3: the running sum moves only on an accepted sample or a clear
  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && !clr) |=> $stable(acc_q));

  // R5: the window result changes only when a window closes
  assert_sum_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && last && !clr) |=> $stable(sum_q));

endmodule

// File: rtl/pn_lms_ctrl.sv
module pn_lms_ctrl
  import pn_lms_pkg::*;
#(
  parameter int NUM_STAGES = 3,
  parameter int RES_W      = 14,
  parameter int COEF_W     = 24,
  parameter int MAX_LOG2N  = 12,
  parameter int SH_W       = 4,
  parameter int LOGN_W     = 4,
  parameter int STG_W      = 2,
  parameter int ACC_W      = 27,
  parameter int G_INIT     = 0,
  parameter int A_INIT     = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [LOGN_W-1:0]              win_log2,
  input  logic [SH_W-1:0]                mu_g_shift,
  input  logic [SH_W-1:0]                mu_a_shift,
  input  logic [RES_W-1:0]               quiet_thr,
  input  logic                           sample_valid,
  input  logic signed [ACC_W-1:0]        sum_g,
  input  logic signed [ACC_W-1:0]        sum_a,
  output logic                           acc_en,
  output logic                           win_last,
  output logic                           acc_clr,
  output logic [NUM_STAGES*COEF_W-1:0]   gain_flat,
  output logic [NUM_STAGES*COEF_W-1:0]   cubic_flat,
  output logic [STG_W-1:0]               active_stage,
  output logic [NUM_STAGES-1:0]          stage_done,
  output logic                           all_done
);

  localparam int CNT_W = (MAX_LOG2N > 0) ? MAX_LOG2N : 1;
  localparam int EXT_W = COEF_W - RES_W - 1;
  localparam logic signed [ACC_W-1:0] AVG_LIM = ACC_W'(1) <<< (RES_W - 1);

  cal_state_e              state_q;
  logic [LOGN_W-1:0]       log2_q;
  logic [SH_W-1:0]         mug_q;
  logic [SH_W-1:0]         mua_q;
  logic [RES_W-1:0]        thr_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    win_end_q;
  logic                    quiet_q;
  logic [STG_W-1:0]        act_q;
  logic [NUM_STAGES-1:0]   done_q;
  logic                    all_q;
  logic signed [COEF_W-1:0] g_mem [NUM_STAGES];
  logic signed [COEF_W-1:0] a_mem [NUM_STAGES];

  logic                    running;
  logic [CNT_W-1:0]        win_mask;
  logic signed [ACC_W-1:0] avg_g;
  logic signed [ACC_W-1:0] avg_a;
  logic [ACC_W-1:0]        mag_g;
  logic [ACC_W-1:0]        mag_a;
  logic [ACC_W-1:0]        thr_ext;
  logic                    quiet_now;
  logic                    upd;
  logic                    retire;
  logic signed [RES_W:0]   avg_gt;
  logic signed [RES_W:0]   avg_at;
  logic signed [RES_W:0]   step_g;
  logic signed [RES_W:0]   step_a;
  logic signed [COEF_W-1:0] step_g_ext;
  logic signed [COEF_W-1:0] step_a_ext;
  logic [LOGN_W-1:0]       log2_in;

  assign running   = (state_q == CAL_RUN);
  assign win_mask  = {CNT_W{1'b1}} >> (LOGN_W'(MAX_LOG2N) - log2_q);
  assign acc_en    = running & sample_valid;
  assign win_last  = (cnt_q == win_mask);

  assign avg_g     = sum_g >>> log2_q;
  assign avg_a     = sum_a >>> log2_q;
  assign mag_g     = avg_g[ACC_W-1] ? -avg_g : avg_g;
  assign mag_a     = avg_a[ACC_W-1] ? -avg_a : avg_a;
  assign thr_ext   = ACC_W'(thr_q);
  assign quiet_now = (mag_g < thr_ext) && (mag_a < thr_ext);

  assign upd       = win_end_q & running;
  assign retire    = upd & quiet_now & quiet_q;
  assign acc_clr   = start | retire;

  assign avg_gt     = avg_g[RES_W:0];
  assign avg_at     = avg_a[RES_W:0];
  assign step_g     = avg_gt >>> mug_q;
  assign step_a     = avg_at >>> mua_q;
  assign step_g_ext = {{EXT_W{step_g[RES_W]}}, step_g};
  assign step_a_ext = {{EXT_W{step_a[RES_W]}}, step_a};

  assign log2_in = (win_log2 > LOGN_W'(MAX_LOG2N)) ? LOGN_W'(MAX_LOG2N) : win_log2;

  // window counter and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= CAL_IDLE;
      log2_q    <= '0;
      mug_q     <= '0;
      mua_q     <= '0;
      thr_q     <= '0;
      cnt_q     <= '0;
      win_end_q <= 1'b0;
      quiet_q   <= 1'b0;
      act_q     <= STG_W'(NUM_STAGES - 1);
      done_q    <= '0;
      all_q     <= 1'b0;
    end else begin
      win_end_q <= acc_en & win_last & ~acc_clr;
      if (acc_clr) begin
        cnt_q <= '0;
      end else if (acc_en) begin
        cnt_q <= win_last ? '0 : cnt_q + 1'b1;
      end

      if (start) begin
        state_q <= CAL_RUN;
        log2_q  <= log2_in;
        mug_q   <= mu_g_shift;
        mua_q   <= mu_a_shift;
        thr_q   <= quiet_thr;
        act_q   <= STG_W'(NUM_STAGES - 1);
        done_q  <= '0;
        all_q   <= 1'b0;
        quiet_q <= 1'b0;
      end else if (upd) begin
        if (quiet_now) begin
          if (quiet_q) begin
            done_q[act_q] <= 1'b1;
            quiet_q       <= 1'b0;
            if (act_q == '0) begin
              state_q <= CAL_IDLE;
              all_q   <= 1'b1;
            end else begin
              act_q <= act_q - 1'b1;
            end
          end else begin
            quiet_q <= 1'b1;
          end
        end else begin
          quiet_q <= 1'b0;
        end
      end
    end
  end

  // coefficient registers, one write port at the active index
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_STAGES; s++) begin
        g_mem[s] <= COEF_W'(G_INIT);
        a_mem[s] <= COEF_W'(A_INIT);
      end
    end else if (upd && !start) begin
      g_mem[act_q] <= g_mem[act_q] + step_g_ext;
      a_mem[act_q] <= a_mem[act_q] + step_a_ext;
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_flat
    assign gain_flat[s*COEF_W +: COEF_W]  = g_mem[s];
    assign cubic_flat[s*COEF_W +: COEF_W] = a_mem[s];
  end

  assign active_stage = act_q;
  assign stage_done   = done_q;
  assign all_done     = all_q;

  // R6/R9: coefficients move only on a window-end update
  assert_coef_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(gain_flat) && $stable(cubic_flat)));

  // R5: a window average of in-range residuals stays in range
  assert_avg_range_R5: assert property (@(posedge clk) disable iff (rst)
    upd |-> (avg_g <= AVG_LIM && avg_g >= -AVG_LIM &&
             avg_a <= AVG_LIM && avg_a >= -AVG_LIM));

  // R8: stages are visited downward within a run
  assert_order_R8: assert property (@(posedge clk) disable iff (rst)
    (running && !start) |=> (act_q <= $past(act_q)));

  // R7: a retired stage stays retired for the rest of the run
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (running && !start) |=> ((done_q & $past(done_q)) == $past(done_q)));

  // R8: finishing implies every stage retired
  assert_alldone_R8: assert property (@(posedge clk) disable iff (rst)
    all_q |-> (&done_q));

endmodule

// File: rtl/pn_lms_estimator.sv
module pn_lms_estimator
  import pn_lms_pkg::*;
#(
  parameter int NUM_STAGES = 3,
  parameter int RES_W      = 14,
  parameter int COEF_W     = 24,
  parameter int MAX_LOG2N  = 12,
  parameter int SH_W       = 4,
  parameter int G_INIT     = 0,
  parameter int A_INIT     = 0,
  localparam int LOGN_W    = $clog2(MAX_LOG2N + 1),
  localparam int STG_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [LOGN_W-1:0]             win_log2,
  input  logic [SH_W-1:0]               mu_g_shift,
  input  logic [SH_W-1:0]               mu_a_shift,
  input  logic [RES_W-1:0]              quiet_thr,
  input  logic                          sample_valid,
  input  logic signed [RES_W-1:0]       residual,
  output logic [2:0]                    pn_bits,
  output logic [STG_W-1:0]              active_stage,
  output logic [NUM_STAGES*COEF_W-1:0]  gain_coef,
  output logic [NUM_STAGES*COEF_W-1:0]  cubic_coef,
  output logic [NUM_STAGES-1:0]         stage_done,
  output logic                          all_done
);

  localparam int ACC_W = RES_W + MAX_LOG2N + 1;

  logic                    acc_en;
  logic                    win_last;
  logic                    acc_clr;
  logic [1:0]              corr_pos;
  logic signed [ACC_W-1:0] corr_sum [2];

  for (genvar k = 0; k < 3; k++) begin : g_pn
    pn_lfsr #(
      .W    (PN_W),
      .TAPS (pn_taps(k)),
      .SEED (pn_seed(k))
    ) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .adv   (sample_valid),
      .bit_o (pn_bits[k])
    );
  end

  assign corr_pos[0] = pn_bits[0];
  assign corr_pos[1] = cubic_pos(pn_bits);

  for (genvar k = 0; k < 2; k++) begin : g_corr
    pn_correlator #(
      .RES_W (RES_W),
      .ACC_W (ACC_W)
    ) u_corr (
      .clk      (clk),
      .rst      (rst),
      .clr      (acc_clr),
      .acc_en   (acc_en),
      .last     (win_last),
      .sgn_pos  (corr_pos[k]),
      .residual (residual),
      .sum_o    (corr_sum[k])
    );
  end

  pn_lms_ctrl #(
    .NUM_STAGES (NUM_STAGES),
    .RES_W      (RES_W),
    .COEF_W     (COEF_W),
    .MAX_LOG2N  (MAX_LOG2N),
    .SH_W       (SH_W),
    .LOGN_W     (LOGN_W),
    .STG_W      (STG_W),
    .ACC_W      (ACC_W),
    .G_INIT     (G_INIT),
    .A_INIT     (A_INIT)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .win_log2     (win_log2),
    .mu_g_shift   (mu_g_shift),
    .mu_a_shift   (mu_a_shift),
    .quiet_thr    (quiet_thr),
    .sample_valid (sample_valid),
    .sum_g        (corr_sum[0]),
    .sum_a        (corr_sum[1]),
    .acc_en       (acc_en),
    .win_last     (win_last),
    .acc_clr      (acc_clr),
    .gain_flat    (gain_coef),
    .cubic_flat   (cubic_coef),
    .active_stage (active_stage),
    .stage_done   (stage_done),
    .all_done     (all_done)
  );

endmodule

// File: tb/pn_lms_estimator_tb_top.sv
module pn_lms_estimator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 3;
  localparam int RW   = 12;
  localparam int CW   = 20;
  localparam int MAXL = 6;
  localparam int SW   = 3;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int STW  = 2;
  localparam int THR  = 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                   rst;
  logic                   start;
  logic [LW-1:0]          win_log2;
  logic [SW-1:0]          mu_g_shift;
  logic [SW-1:0]          mu_a_shift;
  logic [RW-1:0]          quiet_thr;
  logic                   sample_valid;
  logic signed [RW-1:0]   residual;
  logic [2:0]             pn_bits;
  logic [STW-1:0]         active_stage;
  logic [NS*CW-1:0]       gain_coef;
  logic [NS*CW-1:0]       cubic_coef;
  logic [NS-1:0]          stage_done;
  logic                   all_done;

  pn_lms_estimator #(
    .NUM_STAGES (NS), .RES_W (RW), .COEF_W (CW),
    .MAX_LOG2N (MAXL), .SH_W (SW), .G_INIT (0), .A_INIT (0)
  ) dut_i (
    .clk (clk), .rst (rst), .start (start), .win_log2 (win_log2),
    .mu_g_shift (mu_g_shift), .mu_a_shift (mu_a_shift), .quiet_thr (quiet_thr),
    .sample_valid (sample_valid), .residual (residual), .pn_bits (pn_bits),
    .active_stage (active_stage), .gain_coef (gain_coef), .cubic_coef (cubic_coef),
    .stage_done (stage_done), .all_done (all_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int exp_g [NS];
  int exp_a [NS];
  int gt [NS];
  int at [NS];
  int exp_act;
  bit [NS-1:0] exp_done;
  bit exp_all;
  bit exp_q;
  int cur_L, cur_mg, cur_ma;
  int pn_hist [8];

  function automatic int coef_g(input int s);
    return $signed(gain_coef[s*CW +: CW]);
  endfunction

  function automatic int coef_a(input int s);
    return $signed(cubic_coef[s*CW +: CW]);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_state();
    for (int s = 0; s < NS; s++) begin
      chk("R3 R5 R6 gain coefficient", coef_g(s), exp_g[s]);
      chk("R4 R5 R6 cubic coefficient", coef_a(s), exp_a[s]);
    end
    chk("R7 active stage", active_stage, exp_act);
    chk("R7 stage done bits", stage_done, exp_done);
    chk("R8 finished flag", all_done, exp_all);
  endtask

  task automatic run_window();
    longint sg, sa, ag, aa;
    int n;
    bit quiet;
    sg = 0; sa = 0;
    n = 1 << cur_L;
    for (int i = 0; i < n; i++) begin
      int s1, s2, s3, sp, eg, ea, r;
      @(negedge clk);
      if (i == n/2)
        chk("R10 no update before latched length", coef_g(exp_act), exp_g[exp_act]);
      s1 = pn_bits[0] ? 1 : -1;
      s2 = pn_bits[1] ? 1 : -1;
      s3 = pn_bits[2] ? 1 : -1;
      sp = s1 * s2 * s3;
      pn_hist[pn_bits]++;
      eg = gt[exp_act] - coef_g(exp_act);
      ea = at[exp_act] - coef_a(exp_act);
      r  = eg*s1 + ea*sp + s2;
      residual     = RW'(r);
      sample_valid = 1'b1;
      sg += longint'(s1 * r);
      sa += longint'(sp * r);
      @(negedge clk);
      sample_valid = 1'b0;
    end
    @(negedge clk);
    ag = sg >>> cur_L;
    aa = sa >>> cur_L;
    exp_g[exp_act] += int'(ag >>> cur_mg);
    exp_a[exp_act] += int'(aa >>> cur_ma);
    quiet = (ag < THR && ag > -THR) && (aa < THR && aa > -THR);
    if (quiet) begin
      if (exp_q) begin
        exp_done[exp_act] = 1'b1;
        exp_q = 1'b0;
        if (exp_act == 0) exp_all = 1'b1;
        else exp_act--;
      end else begin
        exp_q = 1'b1;
      end
    end else begin
      exp_q = 1'b0;
    end
    check_state();
  endtask

  task automatic idle_samples(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      residual     = RW'(700 - 150*i);
      sample_valid = 1'b1;
      @(negedge clk);
      sample_valid = 1'b0;
    end
    @(negedge clk);
    check_state();
    chk("R9 idle samples leave stage-0 gain", coef_g(0), exp_g[0]);
  endtask

  task automatic do_run(input int r, input int L, input int mg, input int ma);
    int windows;
    for (int s = 0; s < NS; s++) begin
      gt[s] = 40*(s+1) - 25*r;
      at[s] = -30*(s+1) + 17*r;
    end
    win_log2   = LW'(L);
    mu_g_shift = SW'(mg);
    mu_a_shift = SW'(ma);
    quiet_thr  = RW'(THR);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cur_L = L; cur_mg = mg; cur_ma = ma;
    exp_act = NS - 1; exp_done = '0; exp_all = 1'b0; exp_q = 1'b0;
    chk("R8 start sets top stage", active_stage, NS - 1);
    chk("R8 start clears done bits", stage_done, 0);
    chk("R8 start clears finished", all_done, 0);
    chk("R8 start keeps coefficients", coef_g(NS-1), exp_g[NS-1]);
    // R10: disturb the configuration ports after start
    win_log2   = (L == 2) ? LW'(5) : LW'(1);
    mu_g_shift = SW'(0);
    quiet_thr  = RW'(200);
    windows = 0;
    while (!exp_all && windows < 60) begin
      run_window();
      windows++;
    end
    chk("R7 R8 run reached finish", all_done, 1);
    idle_samples(4);
  endtask

  initial begin
    int pn0;
    int run_idx;
    rst = 1'b1; start = 1'b0; sample_valid = 1'b0; residual = '0;
    win_log2 = '0; mu_g_shift = '0; mu_a_shift = '0; quiet_thr = '0;
    for (int c = 0; c < 8; c++) pn_hist[c] = 0;
    for (int s = 0; s < NS; s++) begin exp_g[s] = 0; exp_a[s] = 0; end
    exp_act = NS - 1; exp_done = '0; exp_all = 1'b0; exp_q = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state();
    chk("R1 reset active stage", active_stage, NS - 1);
    // R2: bits hold without accepted samples
    pn0 = int'(pn_bits);
    repeat (5) @(negedge clk);
    chk("R2 dither bits hold while idle", pn_bits, pn0);
    // R9: samples before any start are ignored
    idle_samples(3);
    run_idx = 0;
    for (int L = 2; L <= 4; L++)
      for (int mg = 1; mg <= 2; mg++)
        for (int ma = 1; ma <= 2; ma++) begin
          do_run(run_idx, L, mg, ma);
          run_idx++;
        end
    for (int c = 0; c < 8; c++)
      chk("R2 dither combination occurs", pn_hist[c] > 0, 1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule